// File: doc/BRIEF.md
# Clock Output Power-Down and Mode Sequencer

This block decides, for a clock synthesizer, when each output clock group may run and how the output stage behaves. It takes an asynchronous active-low power-down request, synchronizes it, and then shuts the groups off in a fixed order. The reference group goes first, then the CPU, PCI and free-running PCI groups. Once every group is off, the internal clocks are stopped. When the request is released, a stabilization timer runs before any group is allowed to run again.

The gate cells of the groups are controlled through one enable per group. The block only changes an enable during the low phase of its group, which each gate cell reports on `grp_low`. Because of this, every stop leaves the output low and every start begins with a full high pulse. A two-bit mode input selects one of four settings: tri-stated outputs, active 66 MHz, active 100 MHz, or a test mode. In test mode, dividers running from the block clock (the externally driven test clock) supply the CPU rate (divide by 2) and the PCI rate (divide by 6). A new mode is applied only in the running state, and only after every group enable has dropped.

Top module: `clk_pm_sequencer`

## Requirements
- R1: `pwrdn_n` passes through a two-stage synchronizer. A power-down request driven before clock edge 1 changes no enable at or before edge 3.
- R2: Power-down stops the reference group first. `ref_en` falls while the CPU, PCI and free-running PCI enables still hold. Those three enables are cleared only after `ref_en` is low.
- R3: An enable (bit 0 reference, bit 1 CPU, bit 2 PCI, bit 3 free-running PCI of `grp_low`) changes only at a clock edge where that group's `grp_low` bit is 1.
- R4: `core_run` falls one edge after all enables are off during power-down. While powered down, `cpu_run` and `pci_run` have no effect and all enables stay 0.
- R5: After the request is released, `core_run` rises at the third edge. With WAKE_CYCLES = W, the state returns to running at edge 3+W and the enables return at edge 4+W, when the groups are low. Until then all enables stay 0.
- R6: A power-down request that arrives during the stabilization wait returns the block to the powered-down state (`core_run` = 0) three edges after it is driven, and the wait restarts on the next release.
- R7: Mode codes on `mode_sel` are: 2'b00 tri-state, 2'b01 active 66 MHz, 2'b10 test, 2'b11 active 100 MHz. `src_sel` carries the applied code, and `out_hiz` is 1 only for 2'b00.
- R8: A mode change in the running state clears all enables at the next edge, applies the new code at the edge after that, and restores the enables one edge later. A mode change while powered down is not applied; the code present at wake-up is loaded when the wait ends.
- R9: In test mode, `tst_cpu` toggles on every edge and `tst_pci` toggles every third edge. Both start from 0 the edge after the test code is applied. Outside test mode both are held 0.
- R10: In an active mode, `cpu_en` follows `cpu_run` and `pci_en` follows `pci_run`, while `ref_en` and `pcif_en` are 1 regardless of either input.
- R11: During and after reset, the block is powered down: all enables 0, `core_run` 0, `out_hiz` 1, `src_sel` 2'b00, and both test outputs 0.
- R12: In tri-state mode, every enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock (crystal or test clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| mode_sel | input | 2 | Requested output mode code |
| cpu_run | input | 1 | CPU group run request (1 = run) |
| pci_run | input | 1 | PCI group run request (1 = run) |
| grp_low | input | 4 | Per-group low-phase flag from the gate cells |
| ref_en | output | 1 | Reference group enable |
| cpu_en | output | 1 | CPU group enable |
| pci_en | output | 1 | PCI group enable |
| pcif_en | output | 1 | Free-running PCI group enable |
| out_hiz | output | 1 | Tri-state all output drivers |
| src_sel | output | 2 | Applied mode code, selects clock source |
| core_run | output | 1 | Internal clock run (0 while powered down) |
| tst_cpu | output | 1 | Test clock divided by 2 |
| tst_pci | output | 1 | Test clock divided by 6 |

## Verification
Most wrong internal states appear at the enable pins within one or two edges. A sequencer stuck past the reference step shows `ref_en` low while the other enables are frozen high. A missed transition to the powered-down state leaves `core_run` high one edge too long. An early exit from the stabilization wait brings the enables back before edge 4+W. A mode register updated too early shows up as `src_sel` changing while an enable is still 1, or as `out_hiz` rising with groups enabled. Divider errors show up within six edges as a wrong phase of `tst_cpu` or `tst_pci`.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    localparam int NUM_GRP  = 4;
    localparam int GRP_REF  = 0;
    localparam int GRP_CPU  = 1;
    localparam int GRP_PCI  = 2;
    localparam int GRP_PCIF = 3;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STOP_REF = 3'd1,
        ST_STOP_ALL = 3'd2,
        ST_DOWN     = 3'd3,
        ST_WAKE     = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_HIZ  = 2'b00,
        MODE_F66  = 2'b01,
        MODE_TEST = 2'b10,
        MODE_F100 = 2'b11
    } out_mode_e;

    typedef struct packed {
        seq_state_e         state;
        out_mode_e          mode;
        logic [NUM_GRP-1:0] en;
    } seq_regs_t;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cps_wake_timer.sv
module cps_wake_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done = run && (cnt_q == LAST);

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (done) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cps_clk_div.sv
module cps_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic div_out
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TURN = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          out_d, out_q;

    always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        if (!active) begin
            cnt_d = '0;
            out_d = 1'b0;
        end else if (cnt_q == TURN) begin
            cnt_d = '0;
            out_d = ~out_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    assign div_out = out_q;
endmodule

// File: rtl/clk_pm_sequencer.sv
module clk_pm_sequencer
    import clkseq_pkg::*;
#(
    parameter int WAKE_CYCLES = 40000,
    parameter int SYNC_STAGES = 2,
    parameter int CPU_DIV     = 2,
    parameter int PCI_DIV     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrdn_n,
    input  logic [1:0] mode_sel,
    input  logic       cpu_run,
    input  logic       pci_run,
    input  logic [3:0] grp_low,
    output logic       ref_en,
    output logic       cpu_en,
    output logic       pci_en,
    output logic       pcif_en,
    output logic       out_hiz,
    output logic [1:0] src_sel,
    output logic       core_run,
    output logic       tst_cpu,
    output logic       tst_pci
);
    localparam int NUM_DIV = 2;

    seq_regs_t          r_d, r_q;
    logic               pd_sync;
    logic               pd_req;
    logic               wake_done;
    logic [NUM_GRP-1:0] tgt;
    logic [NUM_GRP-1:0] en_vec;
    logic [NUM_DIV-1:0] tst_vec;
    logic               div_active;
    logic               seq_in_stop_ref;
    logic               seq_in_wake;

    // Power-down request crosses into the clk domain; reset value = requested.
    cps_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b0)
    ) pd_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwrdn_n),
        .dout (pd_sync)
    );

    assign pd_req = ~pd_sync;

    cps_wake_timer #(
        .CYCLES(WAKE_CYCLES)
    ) wake_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.state == ST_WAKE),
        .done (wake_done)
    );

    // Run targets for an active mode: stop inputs only touch their own group.
    function automatic logic [NUM_GRP-1:0] mode_targets(out_mode_e m, logic c_run, logic p_run);
        logic [NUM_GRP-1:0] t;
        t = '0;
        if (m != MODE_HIZ) begin
            t[GRP_REF]  = 1'b1;
            t[GRP_CPU]  = c_run;
            t[GRP_PCI]  = p_run;
            t[GRP_PCIF] = 1'b1;
        end
        return t;
    endfunction

    always_comb begin
        r_d = r_q;
        tgt = r_q.en;
        unique case (r_q.state)
            ST_RUN: begin
                if (pd_req) begin
                    r_d.state = ST_STOP_REF;
                end else if (out_mode_e'(mode_sel) != r_q.mode) begin
                    tgt = '0;
                    if (r_q.en == '0) begin
                        r_d.mode = out_mode_e'(mode_sel);
                    end
                end else begin
                    tgt = mode_targets(r_q.mode, cpu_run, pci_run);
                end
            end
            ST_STOP_REF: begin
                tgt[GRP_REF] = 1'b0;
                if (!r_q.en[GRP_REF]) begin
                    r_d.state = ST_STOP_ALL;
                end
            end
            ST_STOP_ALL: begin
                tgt = '0;
                if (r_q.en == '0) begin
                    r_d.state = ST_DOWN;
                end
            end
            ST_DOWN: begin
                tgt = '0;
                if (!pd_req) begin
                    r_d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                tgt = '0;
                if (pd_req) begin
                    r_d.state = ST_DOWN;
                end else if (wake_done) begin
                    r_d.state = ST_RUN;
                    r_d.mode  = out_mode_e'(mode_sel);
                end
            end
            default: begin
                tgt       = '0;
                r_d.state = ST_DOWN;
            end
        endcase

        // An enable moves only while its group sits in the low phase.
        for (int g = 0; g < NUM_GRP; g++) begin
            r_d.en[g] = grp_low[g] ? tgt[g] : r_q.en[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_DOWN;
            r_q.mode  <= MODE_HIZ;
            r_q.en    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_active = (r_q.mode == MODE_TEST) && (r_q.state != ST_DOWN);

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        cps_clk_div #(
            .DIV((i == 0) ? CPU_DIV : PCI_DIV)
        ) div_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (div_active),
            .div_out(tst_vec[i])
        );
    end

    assign en_vec          = r_q.en;
    assign seq_in_stop_ref = (r_q.state == ST_STOP_REF);
    assign seq_in_wake     = (r_q.state == ST_WAKE);

    assign ref_en   = r_q.en[GRP_REF];
    assign cpu_en   = r_q.en[GRP_CPU];
    assign pci_en   = r_q.en[GRP_PCI];
    assign pcif_en  = r_q.en[GRP_PCIF];
    assign out_hiz  = (r_q.mode == MODE_HIZ);
    assign src_sel  = r_q.mode;
    assign core_run = (r_q.state != ST_DOWN);
    assign tst_cpu  = tst_vec[0];
    assign tst_pci  = tst_vec[1];
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] grp_low,
    input logic [3:0] en_vec,
    input logic       core_run,
    input logic       out_hiz,
    input logic [1:0] src_sel,
    input logic       in_stop_ref,
    input logic       in_wake
);
    // R3
    en_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_vec ^ $past(en_vec)) & ~$past(grp_low)) == 4'b0000);

    // R4
    down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |-> (en_vec == 4'b0000));

    // R12
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz |-> (en_vec == 4'b0000));

    // R2
    ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop_ref |=> (en_vec[3:1] == $past(en_vec[3:1])));

    // R8
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel) |-> (en_vec == 4'b0000 && $past(en_vec) == 4'b0000));

    // R5
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wake |-> (en_vec == 4'b0000));
endmodule

bind clk_pm_sequencer cps_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_low    (grp_low),
    .en_vec     (en_vec),
    .core_run   (core_run),
    .out_hiz    (out_hiz),
    .src_sel    (src_sel),
    .in_stop_ref(seq_in_stop_ref),
    .in_wake    (seq_in_wake)
);

// File: tb/clk_pm_sequencer_test.sv
module clk_pm_sequencer_test;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwrdn_n;
    logic [1:0] mode_sel;
    logic       cpu_run;
    logic       pci_run;
    logic [3:0] grp_low;
    logic       ref_en, cpu_en, pci_en, pcif_en;
    logic       out_hiz;
    logic [1:0] src_sel;
    logic       core_run;
    logic       tst_cpu, tst_pci;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    clk_pm_sequencer #(.WAKE_CYCLES(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .mode_sel(mode_sel),
        .cpu_run (cpu_run),
        .pci_run (pci_run),
        .grp_low (grp_low),
        .ref_en  (ref_en),
        .cpu_en  (cpu_en),
        .pci_en  (pci_en),
        .pcif_en (pcif_en),
        .out_hiz (out_hiz),
        .src_sel (src_sel),
        .core_run(core_run),
        .tst_cpu (tst_cpu),
        .tst_pci (tst_pci)
    );

    wire [3:0] en = {pcif_en, pci_en, cpu_en, ref_en};

    // {cpu_run, pci_run, grp_low[3:0], expected enables {pcif,pci,cpu,ref}}
    localparam logic [9:0] VEC [7] = '{
        {1'b0, 1'b1, 4'b1111, 4'b1101},
        {1'b1, 1'b0, 4'b0000, 4'b1101},
        {1'b1, 1'b0, 4'b0010, 4'b1111},
        {1'b1, 1'b0, 4'b0100, 4'b1011},
        {1'b0, 1'b0, 4'b1111, 4'b1001},
        {1'b1, 1'b1, 4'b1011, 4'b1011},
        {1'b1, 1'b1, 4'b1111, 4'b1111}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        pwrdn_n  = 1'b1;
        mode_sel = 2'b01;
        cpu_run  = 1'b1;
        pci_run  = 1'b1;
        grp_low  = 4'b1111;
        step(3);
        // R11 reset state
        check("R11 en", en, 4'b0000);
        check("R11 core_run", core_run, 0);
        check("R11 out_hiz", out_hiz, 1);
        check("R11 src_sel", src_sel, 2'b00);
        check("R11 tst", {tst_cpu, tst_pci}, 2'b00);
        rst_n = 1'b1;
        // R5 first wake after reset
        step(3);
        check("R5 core_run in wait", core_run, 1);
        check("R5 en in wait", en, 4'b0000);
        step(W);
        check("R5 en at 3+W", en, 4'b0000);
        step(1);
        check("R5 en at 4+W", en, 4'b1111);
        check("R7 src 66", src_sel, 2'b01);
        check("R7 hiz off", out_hiz, 0);

        // R10 and R3 table of stop inputs against low phases
        for (int i = 0; i < 7; i++) begin
            cpu_run = VEC[i][9];
            pci_run = VEC[i][8];
            grp_low = VEC[i][7:4];
            step(1);
            check("R10/R3 table", en, VEC[i][3:0]);
        end

        // R8 switch 66 -> 100
        mode_sel = 2'b11;
        step(1);
        check("R8 drop", en, 4'b0000);
        check("R8 old code", src_sel, 2'b01);
        step(1);
        check("R8 apply", src_sel, 2'b11);
        check("R8 still off", en, 4'b0000);
        step(1);
        check("R8 restore", en, 4'b1111);

        // R9 test mode
        mode_sel = 2'b10;
        step(2);
        check("R7 test code", src_sel, 2'b10);
        for (int j = 1; j <= 12; j++) begin
            step(1);
            check("R9 tst_cpu", tst_cpu, j % 2);
            check("R9 tst_pci", tst_pci, (j / 3) % 2);
        end

        // R12 tri-state mode
        mode_sel = 2'b00;
        step(2);
        check("R7 hiz on", out_hiz, 1);
        check("R7 hiz code", src_sel, 2'b00);
        step(1);
        check("R12 en off", en, 4'b0000);
        check("R9 held", {tst_cpu, tst_pci}, 2'b00);
        mode_sel = 2'b01;
        step(1);
        check("R8 leave hiz", out_hiz, 0);
        step(1);
        check("R8 en back", en, 4'b1111);

        // R1 R2 R4 counted power-down entry
        pwrdn_n = 1'b0;
        step(3);
        check("R1 no early stop", en, 4'b1111);
        step(1);
        check("R2 ref first", en, 4'b1110);
        step(2);
        check("R2 rest off", en, 4'b0000);
        check("R4 core still on", core_run, 1);
        step(1);
        check("R4 core off", core_run, 0);

        // R4 stop inputs ignored, R8 mode not applied while down
        cpu_run  = 1'b0;
        pci_run  = 1'b0;
        mode_sel = 2'b11;
        step(2);
        cpu_run = 1'b1;
        pci_run = 1'b1;
        step(2);
        check("R4 ignored", en, 4'b0000);
        check("R8 no change down", src_sel, 2'b01);

        // R5 release, R8 code loaded at wake end
        pwrdn_n = 1'b1;
        step(3);
        check("R5 core on", core_run, 1);
        step(W);
        check("R5 en wait", en, 4'b0000);
        check("R8 loaded", src_sel, 2'b11);
        step(1);
        check("R5 en back", en, 4'b1111);

        // R6 request during wait
        pwrdn_n = 1'b0;
        step(7);
        check("R6 down", core_run, 0);
        pwrdn_n = 1'b1;
        step(5);
        check("R6 waiting", core_run, 1);
        pwrdn_n = 1'b0;
        step(3);
        check("R6 aborted", core_run, 0);
        step(W + 2);
        check("R6 en off", en, 4'b0000);
        pwrdn_n = 1'b1;
        step(3 + W);
        check("R6 restart wait", en, 4'b0000);
        step(1);
        check("R6 restarted", en, 4'b1111);

        // R3 groups held high stall the stop order
        grp_low = 4'b0000;
        pwrdn_n = 1'b0;
        step(8);
        check("R3 ref held", en, 4'b1111);
        grp_low = 4'b0001;
        step(3);
        check("R3 only ref", en, 4'b1110);
        check("R3 core on", core_run, 1);
        grp_low = 4'b1111;
        step(1);
        check("R2 rest after ref", en, 4'b0000);
        step(1);
        check("R4 down", core_run, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule